// File: doc/BRIEF.md
# Indirect Register Access Window

This block gives a host that only has a byte-wide I/O path a way into a full 32-bit address space. The host first loads a 32-bit pointer one byte at a time through four pointer ports, then moves a 32-bit word through data byte lanes. Loading the top byte lane of the data word launches one 32-bit write to the location the pointer names. Reading a byte lane of the first data group fetches the word at the pointer and returns the selected byte.

The pointer is steered to one of two downstream targets. The lower 16 MB go to a register space, which receives the low 24 pointer bits. Everything above goes to a linear frame memory, which receives the pointer minus 16 MB. Each target sees a single-cycle strobe with address, write data and write enable, and answers reads combinationally in the same cycle. Any port write whose offset has bit 4 set advances the pointer by one word afterwards, so streaming through the last data group walks through memory.

Four fixed identification bytes can be read at the lowest offsets, so software can probe for the window before using it.

Top module: `ira_window`

## Requirements
- R1: After reset the pointer and the data word are zero, io_rdata is 0x00 and no downstream strobe is active.
- R2: A read of offset 0x00, 0x01, 0x02 or 0x03 returns 0x65, 0xD0, 0x16 or 0x2B respectively on io_rdata one clock later.
- R3: A write to offset 0x04+k (k = 0..3) replaces byte k of the pointer (byte 0 = bits 7:0) and leaves the other three bytes unchanged.
- R4: A write to any offset from 0x08 to 0x17 replaces byte (offset mod 4) of the data word and leaves the other bytes unchanged.
- R5: A write to offset 0x0B, 0x0F, 0x13 or 0x17 raises exactly one write strobe in the same cycle. It carries the data word with the new top byte merged in, and the pointer value from before any increment.
- R6: A pointer below 0x0100_0000 drives reg_req with reg_addr equal to its low 24 bits. A pointer at or above it drives mem_req with mem_addr equal to the pointer minus 0x0100_0000. The two strobes are never active together.
- R7: After any write whose offset has bit 4 set, the pointer increases by 4, wrapping modulo 2^32; this applies to offsets 0x10..0x1F and beyond.
- R8: A read of offset 0x08+k (k = 0..3) raises a read strobe (write enable low) at the current pointer in the same cycle. Byte k of the target's response appears on io_rdata one clock later.
- R9: Reads of every other offset return 0x00 and raise no strobe. Writes to 0x00..0x03 and to offsets above 0x17 change neither the data word nor the pointer (apart from R7) and raise no strobe.
- R10: A cycle with io_wr and io_rd both high is treated as a write only: no read strobe is raised and io_rdata keeps its previous value, as it does in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Host byte write, one cycle per access |
| io_rd | input | 1 | Host byte read, one cycle per access |
| io_ofs | input | 8 | Port offset |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Registered host read byte |
| reg_req | output | 1 | Register space access strobe |
| reg_we | output | 1 | Write enable for a register space access |
| reg_addr | output | 24 | Register space address |
| reg_wdata | output | 32 | Register space write word |
| reg_rdata | input | 32 | Register space combinational response |
| mem_req | output | 1 | Linear memory access strobe |
| mem_we | output | 1 | Write enable for a linear memory access |
| mem_addr | output | 32 | Linear memory address (pointer minus 16 MB) |
| mem_wdata | output | 32 | Linear memory write word |
| mem_rdata | input | 32 | Linear memory combinational response |

## Verification
The bench builds the window with its default widths: a 32-bit pointer, an 8-bit port offset and a 24-bit register space. This places the target split at 16 MB and the wrap point at 2^32. With these values, directed cases reach a pointer at 0x00FF_FFFC stepping across into memory, a pointer at 0x0100_0000 mapping to memory address zero, and 0xFFFF_FFFC wrapping to zero. Both targets are modelled as sixteen-word arrays indexed by pointer bits 5:2, so random traffic repeatedly rewrites and reads back the same words in either space.

// File: rtl/ira_pkg.sv
package ira_pkg;

  typedef enum logic [1:0] {
    PK_IDENT = 2'd0,
    PK_PTR   = 2'd1,
    PK_DATA  = 2'd2,
    PK_NONE  = 2'd3
  } port_kind_e;

  localparam int LANES = 4;

  function automatic logic [7:0] ident_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    ident_byte = 8'h65;
      2'd1:    ident_byte = 8'hD0;
      2'd2:    ident_byte = 8'h16;
      default: ident_byte = 8'h2B;
    endcase
  endfunction

endpackage

// File: rtl/ira_port_decode.sv
module ira_port_decode
  import ira_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic [OFS_W-1:0] ofs,
  output port_kind_e       kind,
  output logic [1:0]       lane,
  output logic             rd_lane,
  output logic             step
);
  localparam logic [OFS_W-1:0] PTR_LO  = OFS_W'(4);
  localparam logic [OFS_W-1:0] DATA_LO = OFS_W'(8);
  localparam logic [OFS_W-1:0] RD_HI   = OFS_W'(12);
  localparam logic [OFS_W-1:0] DATA_HI = OFS_W'(24);

  always_comb begin
    lane    = ofs[1:0];
    step    = ofs[4];
    rd_lane = (ofs >= DATA_LO) && (ofs < RD_HI);
    if (ofs < PTR_LO)       kind = PK_IDENT;
    else if (ofs < DATA_LO) kind = PK_PTR;
    else if (ofs < DATA_HI) kind = PK_DATA;
    else                    kind = PK_NONE;
  end
endmodule

// File: rtl/ira_target_steer.sv
module ira_target_steer #(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 24,
  parameter int DATA_W = 32
) (
  input  logic              acc_req,
  input  logic [ADDR_W-1:0] ptr,
  output logic              reg_req,
  output logic [REG_AW-1:0] reg_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rsp_word
);
  localparam logic [ADDR_W-1:0] SPLIT = ADDR_W'(1) << REG_AW;

  logic to_mem;

  assign to_mem   = |ptr[ADDR_W-1:REG_AW];
  assign reg_req  = acc_req && !to_mem;
  assign mem_req  = acc_req && to_mem;
  assign reg_addr = ptr[REG_AW-1:0];
  assign mem_addr = ptr - SPLIT;
  assign rsp_word = to_mem ? mem_rdata : reg_rdata;
endmodule

// File: rtl/ira_window.sv
module ira_window
  import ira_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 24,
  parameter int OFS_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [OFS_W-1:0]  io_ofs,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              reg_req,
  output logic              reg_we,
  output logic [REG_AW-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int PTR_BYTES = ADDR_W / 8;
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(DATA_W / 8);

  logic [ADDR_W-1:0] ptr_q, ptr_merged, ptr_nxt;
  logic [DATA_W-1:0] data_q, data_nxt, rsp_word;
  logic [7:0]        rdata_q;

  port_kind_e kind;
  logic [1:0] lane;
  logic       rd_lane, step;
  logic       hit_ptr, hit_data, wr_fire, rd_fire, rd_take;

  ira_port_decode #(.OFS_W(OFS_W)) u_decode (
    .ofs     (io_ofs),
    .kind    (kind),
    .lane    (lane),
    .rd_lane (rd_lane),
    .step    (step)
  );

  assign hit_ptr  = io_wr && (kind == PK_PTR);
  assign hit_data = io_wr && (kind == PK_DATA);
  assign wr_fire  = hit_data && (lane == 2'd3);
  assign rd_take  = io_rd && !io_wr;
  assign rd_fire  = rd_take && rd_lane;

  for (genvar g = 0; g < LANES; g++) begin : g_data_lane
    assign data_nxt[8*g +: 8] = (hit_data && lane == 2'(g)) ? io_wdata : data_q[8*g +: 8];
  end

  for (genvar g = 0; g < PTR_BYTES; g++) begin : g_ptr_lane
    if (g < LANES) begin : g_wr
      assign ptr_merged[8*g +: 8] = (hit_ptr && lane == 2'(g)) ? io_wdata : ptr_q[8*g +: 8];
    end else begin : g_keep
      assign ptr_merged[8*g +: 8] = ptr_q[8*g +: 8];
    end
  end

  assign ptr_nxt = (io_wr && step) ? ptr_merged + WORD_STEP : ptr_merged;

  ira_target_steer #(.ADDR_W(ADDR_W), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_steer (
    .acc_req   (wr_fire || rd_fire),
    .ptr       (ptr_q),
    .reg_req   (reg_req),
    .reg_addr  (reg_addr),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .reg_rdata (reg_rdata),
    .mem_rdata (mem_rdata),
    .rsp_word  (rsp_word)
  );

  assign reg_we    = wr_fire;
  assign mem_we    = wr_fire;
  assign reg_wdata = data_nxt;
  assign mem_wdata = data_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      ptr_q  <= ptr_nxt;
      data_q <= data_nxt;
      if (rd_take) begin
        if (kind == PK_IDENT) rdata_q <= ident_byte(lane);
        else if (rd_lane)     rdata_q <= rsp_word[8*lane +: 8];
        else                  rdata_q <= 8'h00;
      end
    end
  end

  assign io_rdata = rdata_q;
endmodule

// File: rtl/ira_window_chk.sv
module ira_window_chk #(
  parameter int OFS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             io_wr,
  input logic             io_rd,
  input logic [OFS_W-1:0] io_ofs,
  input logic [7:0]       io_wdata,
  input logic [7:0]       io_rdata,
  input logic             reg_req,
  input logic             reg_we,
  input logic [7:0]       reg_wtop,
  input logic             mem_req,
  input logic             mem_we,
  input logic [7:0]       mem_wtop
);
  logic top_lane, rd_port;
  assign top_lane = (io_ofs == OFS_W'(8'h0B)) || (io_ofs == OFS_W'(8'h0F)) ||
                    (io_ofs == OFS_W'(8'h13)) || (io_ofs == OFS_W'(8'h17));
  assign rd_port  = (io_ofs >= OFS_W'(8'h08)) && (io_ofs <= OFS_W'(8'h0B));

  a_r6_one_target: assert property (@(posedge clk) disable iff (rst)
    !(reg_req && mem_req));

  a_r5_write_fires: assert property (@(posedge clk) disable iff (rst)
    (io_wr && top_lane) |-> ((reg_req || mem_req) && reg_we && mem_we));

  a_r5_reg_top_byte: assert property (@(posedge clk) disable iff (rst)
    (io_wr && top_lane && reg_req) |-> (reg_wtop == io_wdata));

  a_r5_mem_top_byte: assert property (@(posedge clk) disable iff (rst)
    (io_wr && top_lane && mem_req) |-> (mem_wtop == io_wdata));

  a_r8_read_strobe: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !io_wr && rd_port) |-> ((reg_req || mem_req) && !reg_we && !mem_we));

  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    (!io_wr && !(io_rd && rd_port)) |-> (!reg_req && !mem_req));

  a_r2_ident_first: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !io_wr && io_ofs == '0) |=> (io_rdata == 8'h65));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && !io_wr) |=> $stable(io_rdata));
endmodule

bind ira_window ira_window_chk #(.OFS_W(OFS_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .io_wr    (io_wr),
  .io_rd    (io_rd),
  .io_ofs   (io_ofs),
  .io_wdata (io_wdata),
  .io_rdata (io_rdata),
  .reg_req  (reg_req),
  .reg_we   (reg_we),
  .reg_wtop (reg_wdata[DATA_W-1:DATA_W-8]),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_wtop (mem_wdata[DATA_W-1:DATA_W-8])
);

// File: tb/test_ira_window.sv
module test_ira_window;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_ofs = 8'h00, io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        reg_req, reg_we, mem_req, mem_we;
  logic [23:0] reg_addr;
  logic [31:0] mem_addr, reg_wdata, mem_wdata, reg_rdata, mem_rdata;

  logic [31:0] reg_arr [16];
  logic [31:0] mem_arr [16];
  logic [31:0] sh_reg  [16];
  logic [31:0] sh_mem  [16];
  logic [31:0] m_ptr, m_data;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ira_window i_ira_window (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_ofs(io_ofs),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  assign reg_rdata = reg_arr[reg_addr[5:2]];
  assign mem_rdata = mem_arr[mem_addr[5:2]];

  always @(posedge clk) begin
    if (reg_req && reg_we) reg_arr[reg_addr[5:2]] <= reg_wdata;
    if (mem_req && mem_we) mem_arr[mem_addr[5:2]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit in_mem(input logic [31:0] p);
    return p >= 32'h0100_0000;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] ofs);
    logic [31:0] w;
    if (ofs < 8'h04) begin
      case (ofs[1:0])
        2'd0: return 8'h65;
        2'd1: return 8'hD0;
        2'd2: return 8'h16;
        default: return 8'h2B;
      endcase
    end
    if (ofs >= 8'h08 && ofs <= 8'h0B) begin
      w = in_mem(m_ptr) ? sh_mem[m_ptr[5:2]] : sh_reg[m_ptr[5:2]];
      return w[8*ofs[1:0] +: 8];
    end
    return 8'h00;
  endfunction

  task automatic check_strobe(input bit fire, input bit we, input logic [31:0] wd, input string tag);
    if (!fire) begin
      chk(!reg_req && !mem_req, {tag, " no strobe (R9)"}, {30'd0, reg_req, mem_req}, 32'd0);
    end else if (in_mem(m_ptr)) begin
      chk(mem_req && !reg_req && mem_we == we, {tag, " mem strobe (R6)"},
          {29'd0, reg_req, mem_req, mem_we}, {30'd1, we});
      chk(mem_addr == m_ptr - 32'h0100_0000, {tag, " mem addr (R6)"}, mem_addr, m_ptr - 32'h0100_0000);
      if (we) chk(mem_wdata == wd, {tag, " mem wdata (R5)"}, mem_wdata, wd);
    end else begin
      chk(reg_req && !mem_req && reg_we == we, {tag, " reg strobe (R6)"},
          {29'd0, reg_req, mem_req, reg_we}, {29'd0, 2'b10, we});
      chk(reg_addr == m_ptr[23:0], {tag, " reg addr (R6)"}, {8'd0, reg_addr}, {8'd0, m_ptr[23:0]});
      if (we) chk(reg_wdata == wd, {tag, " reg wdata (R5)"}, reg_wdata, wd);
    end
  endtask

  task automatic io_write(input logic [7:0] ofs, input logic [7:0] v);
    logic [31:0] nd;
    bit fire;
    nd = m_data;
    if (ofs >= 8'h08 && ofs <= 8'h17) nd[8*ofs[1:0] +: 8] = v;
    fire = (ofs >= 8'h08 && ofs <= 8'h17 && ofs[1:0] == 2'd3);
    @(negedge clk);
    io_wr = 1'b1; io_ofs = ofs; io_wdata = v;
    #1;
    check_strobe(fire, 1'b1, nd, "R5 write");
    @(posedge clk);
    #1;
    io_wr = 1'b0;
    if (fire) begin
      if (in_mem(m_ptr)) sh_mem[m_ptr[5:2]] = nd;
      else               sh_reg[m_ptr[5:2]] = nd;
    end
    m_data = nd;
    if (ofs >= 8'h04 && ofs <= 8'h07) m_ptr[8*ofs[1:0] +: 8] = v;
    if (ofs[4]) m_ptr = m_ptr + 32'd4;
  endtask

  task automatic io_read(input logic [7:0] ofs, input string tag);
    logic [7:0] e;
    e = exp_rd(ofs);
    @(negedge clk);
    io_rd = 1'b1; io_ofs = ofs;
    #1;
    check_strobe(ofs >= 8'h08 && ofs <= 8'h0B, 1'b0, 32'd0, tag);
    @(posedge clk);
    #1;
    io_rd = 1'b0;
    chk(io_rdata == e, {tag, " read byte"}, {24'd0, io_rdata}, {24'd0, e});
  endtask

  task automatic set_ptr(input logic [31:0] p);
    for (int k = 0; k < 4; k++) io_write(8'h04 + 8'(k), p[8*k +: 8]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      reg_arr[i] = 32'hA500_0000 + 32'(i) * 32'h0001_0203;
      mem_arr[i] = 32'h5A00_0000 + 32'(i) * 32'h0302_0100;
      sh_reg[i]  = reg_arr[i];
      sh_mem[i]  = mem_arr[i];
    end
    m_ptr = 0; m_data = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    // R1: reset state at the ports
    chk(io_rdata == 8'h00, "R1 rdata after reset", {24'd0, io_rdata}, 32'd0);
    chk(!reg_req && !mem_req, "R1 no strobe after reset", {30'd0, reg_req, mem_req}, 32'd0);
    io_read(8'h09, "R1 pointer zero");
    io_write(8'h0B, 8'hC3);           // R1: lower data bytes are zero
    io_read(8'h0B, "R1 R8 readback");

    // R2 identification bytes
    for (int k = 0; k < 4; k++) io_read(8'(k), "R2 ident");

    // R3 pointer bytes, partial update
    set_ptr(32'h0100_0010);
    io_write(8'h06, 8'h00);
    io_write(8'h04, 8'h14);
    io_read(8'h08, "R3 partial pointer");

    // R4 data lanes in several groups, R5 launch
    io_write(8'h0C, 8'h11);
    io_write(8'h11, 8'h22);
    io_write(8'h0A, 8'h33);
    io_write(8'h0F, 8'h44);
    for (int k = 0; k < 4; k++) io_read(8'h08 + 8'(k), "R4 R8 lanes");

    // R7 increment via last group, crossing into memory
    set_ptr(32'h00FF_FFFC);
    io_write(8'h14, 8'hE1);
    io_write(8'h17, 8'h7E);
    io_read(8'h08, "R7 crossed to memory");
    set_ptr(32'h0100_0000);
    io_read(8'h0B, "R6 memory base");
    set_ptr(32'hFFFF_FFFC);
    io_write(8'h10, 8'h01);
    io_read(8'h08, "R7 wrap");

    // R9 undefined offsets
    io_write(8'h20, 8'h99);
    io_write(8'h01, 8'h99);
    io_write(8'h18, 8'h99);           // R7 still advances the pointer
    io_write(8'h45, 8'h99);
    io_read(8'h0A, "R9 R7 after undefined writes");
    io_write(8'h0B, 8'h5C);           // lower bytes unaffected
    io_read(8'h0C, "R9 data port not readable");
    io_read(8'h40, "R9 undefined read");
    io_read(8'hFF, "R9 top offset");

    // R10 simultaneous write and read
    io_read(8'h00, "R10 setup");
    @(negedge clk);
    io_wr = 1'b1; io_rd = 1'b1; io_ofs = 8'h08; io_wdata = 8'h6D;
    #1;
    chk(!reg_req && !mem_req, "R10 no read strobe", {30'd0, reg_req, mem_req}, 32'd0);
    @(posedge clk);
    #1;
    io_wr = 1'b0; io_rd = 1'b0;
    m_data[7:0] = 8'h6D;
    chk(io_rdata == 8'h65, "R10 rdata held", {24'd0, io_rdata}, 32'h65);

    // random traffic
    for (int it = 0; it < 600; it++) begin
      int unsigned op;
      logic [7:0] b;
      op = $urandom % 10;
      b  = 8'($urandom);
      case (op)
        0: begin
          case ($urandom % 3)
            0: b = 8'h00;
            1: b = 8'h01;
            default: b = 8'hFF;
          endcase
          io_write(8'h07, b);
        end
        1: io_write(8'h04 + 8'($urandom % 3), b);
        2, 3, 4: io_write(8'h08 + 8'($urandom % 16), b);
        5, 6, 7: io_read(8'h08 + 8'($urandom % 4), "R8 random read");
        8: io_read(8'($urandom), "R9 random read");
        default: io_write(8'h18 + 8'($urandom % 232), b);
      endcase
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule